// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block times an external bus access to one of five chip-select areas. When an access starts it raises the read or write strobe and decides, from a 16-bit configuration register and the access attributes, whether the external wait pin is honoured for that access. If the pin is honoured, the block waits until the synchronised wait has been seen active and then inactive. It then holds the strobe for a short, programmable number of extra cycles and releases it. A one-cycle completion pulse marks the release.

Software programs the configuration register through a plain write port and reads it back combinationally. The register holds these fields: a 2-bit strobe-release delay for area 4 at bits 15:14, five wait-ignore bits at bits 12:8 (area 0 at bit 8, area 4 at bit 12), and two 2-bit fields in bits 3:0. The field at bits 1:0 is the wait-control field for area 4. The field at bits 3:2 is stored and read back only. For areas 0 to 3, a neighbouring block supplies one flag per area that says whether that area's own wait-control field is non-zero. The external device must raise its wait within a short window after the start, or the access ends as if unwaited.

Top module: `wait_state_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x000B.
- R2: Bits 13 and 7:4 always read as 0 and ignore writes. Writing 0xFFFF reads back 0xDF0F.
- R3: For an honoured area-4 access, the delay code at bits 15:14 sets how long the strobe is held after the release is accepted. Code 00 holds for 1 cycle, 01 for 2 cycles and 10 for 4 cycles. A pin release is accepted two clock edges after the pin is first sampled low, because of the two-stage synchroniser.
- R4: The reserved delay code 11 holds the strobe for 4 cycles, the same as code 10.
- R5: If the wait-ignore bit of the accessed area (bit 8+area) is 1, the wait pin is ignored and the strobe falls one cycle after the start.
- R6: If the accessed area's wait-control field is zero, the wait pin is ignored. For area 4 this field is bits 1:0. For areas 0 to 3 it is given by input flag areaWaitOn[area] being 0.
- R7: An access flagged as synchronous DRAM ignores the wait pin, whatever the ignore bits and wait-control fields hold.
- R8: For areas 0 to 3, the strobe falls one cycle after the wait release is accepted, whatever the delay code holds.
- R9: accessDone is high for exactly one cycle: the first cycle in which the strobe is low again. Only rdStrobe is used for reads and only wrStrobe for writes.
- R10: If the wait is honoured but not seen active within WAIT_WINDOW (3) cycles of the start, the strobe falls 3 cycles after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Configuration register write enable |
| regWdata | input | 16 | Configuration write data |
| regRdata | output | 16 | Configuration read data |
| accStart | input | 1 | One-cycle access start pulse (ignored while busy) |
| accArea | input | 3 | Chip-select area index 0 to 4 |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accSdram | input | 1 | Accessed area is synchronous DRAM |
| areaWaitOn | input | 4 | Per-area non-zero wait-control flags for areas 0 to 3 |
| extWait | input | 1 | Asynchronous external wait, active high |
| rdStrobe | output | 1 | Read strobe held |
| wrStrobe | output | 1 | Write strobe held |
| accessDone | output | 1 | One-cycle completion pulse |

## Verification
Area-4 accesses with a driven wait pulse are run under each of the four delay codes. This separates the 1, 2 and 4 cycle holds and shows that the reserved code matches code 10. The same pulse is then sent to areas 0 to 3, so the one-cycle release can be told apart from area 4's delay. The pulse is also repeated with the ignore bit set, with a zero wait-control field and with the DRAM flag, which gives a one-cycle access each time, and against an unmasked neighbouring area, which keeps the full wait. An honoured access with no wait pulse exercises the fall-back window, and every access is compared cycle by cycle for strobe and done.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACTIVE, ST_HOLD} accState_e;

  typedef struct packed {
    logic capture;
    logic setSeen;
    logic incWin;
    logic loadHold;
    logic decHold;
  } ctlStrobes_t;
endpackage

// File: rtl/wsc_datapath.sv
module wsc_datapath
  import wsc_pkg::*;
#(
  parameter int WAIT_WINDOW = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic [2:0]  accArea,
  input  logic        accWrite,
  input  logic        accSdram,
  input  logic [3:0]  areaWaitOn,
  input  logic        extWait,
  input  ctlStrobes_t strobes,
  output logic        honourQ,
  output logic        writeQ,
  output logic        waitSync,
  output logic        seenQ,
  output logic        holdZero,
  output logic        winLast
);
  localparam int          NUM_AREAS = 5;
  localparam int          MASK_LSB  = 8;
  localparam logic [15:0] WR_MASK   = 16'hDF0F;
  localparam logic [15:0] RST_VAL   = 16'h000B;
  localparam int          WIN_W     = $clog2(WAIT_WINDOW + 1);

  logic [15:0]            cfgReg;
  logic [SYNC_STAGES-1:0] syncChain;
  logic [2:0]             delayQ;
  logic [1:0]             holdCnt;
  logic [WIN_W-1:0]       winCnt;
  logic                   maskBit, fieldOn, areaValid;

  function automatic logic [2:0] holdLen(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;  // 10, and reserved 11 clamps to 4
    endcase
  endfunction

  // configuration register
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)      cfgReg <= RST_VAL;
    else if (regWe) cfgReg <= regWdata & WR_MASK;
  assign regRdata = cfgReg;

  // wait synchroniser
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '0;
        else       syncChain <= extWait;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], extWait};
    end
  endgenerate
  assign waitSync = syncChain[SYNC_STAGES-1];

  // per-area wait qualification
  always_comb begin
    maskBit   = 1'b1;
    fieldOn   = 1'b0;
    areaValid = 1'b0;
    for (int a = 0; a < NUM_AREAS; a++) begin
      if (accArea == 3'(a)) begin
        areaValid = 1'b1;
        maskBit   = cfgReg[MASK_LSB + a];
        fieldOn   = (a == NUM_AREAS - 1) ? (cfgReg[1:0] != 2'b00) : areaWaitOn[a];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      honourQ <= 1'b0;
      writeQ  <= 1'b0;
      delayQ  <= 3'd1;
      seenQ   <= 1'b0;
      winCnt  <= '0;
      holdCnt <= '0;
    end else begin
      if (strobes.capture) begin
        honourQ <= areaValid && fieldOn && !maskBit && !accSdram;
        writeQ  <= accWrite;
        delayQ  <= (accArea == 3'd4) ? holdLen(cfgReg[15:14]) : 3'd1;
        seenQ   <= 1'b0;
        winCnt  <= '0;
      end
      if (strobes.setSeen)  seenQ   <= 1'b1;
      if (strobes.incWin)   winCnt  <= winCnt + 1'b1;
      if (strobes.loadHold) holdCnt <= 2'(delayQ - 3'd1);
      else if (strobes.decHold) holdCnt <= holdCnt - 2'd1;
    end
  end

  assign holdZero = (holdCnt == 2'd0);
  assign winLast  = (winCnt == WIN_W'(WAIT_WINDOW - 1));

  assert_ro_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> (cfgReg[13] == 1'b0 && cfgReg[7:4] == 4'd0));
  assert_mask_ignores_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && areaValid && maskBit) |=> !honourQ);
  assert_sdram_ignores_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && accSdram) |=> !honourQ);
endmodule

// File: rtl/wsc_control.sv
module wsc_control
  import wsc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accStart,
  input  logic        honourQ,
  input  logic        writeQ,
  input  logic        waitSync,
  input  logic        seenQ,
  input  logic        holdZero,
  input  logic        winLast,
  output ctlStrobes_t strobes,
  output logic        rdStrobe,
  output logic        wrStrobe,
  output logic        accessDone
);
  accState_e state, stateNext;
  logic      finish;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    finish    = 1'b0;
    case (state)
      ST_IDLE:
        if (accStart) begin
          strobes.capture = 1'b1;
          stateNext       = ST_ACTIVE;
        end
      ST_ACTIVE:
        if (!honourQ) begin
          finish = 1'b1;
        end else if (seenQ && !waitSync) begin
          strobes.loadHold = 1'b1;
          stateNext        = ST_HOLD;
        end else if (waitSync) begin
          strobes.setSeen = 1'b1;
        end else if (!seenQ && winLast) begin
          finish = 1'b1;
        end else begin
          strobes.incWin = 1'b1;
        end
      ST_HOLD:
        if (holdZero) finish = 1'b1;
        else          strobes.decHold = 1'b1;
      default: stateNext = ST_IDLE;
    endcase
    if (finish) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state      <= ST_IDLE;
      accessDone <= 1'b0;
    end else begin
      state      <= stateNext;
      accessDone <= finish;
    end

  assign rdStrobe = (state != ST_IDLE) && !writeQ;
  assign wrStrobe = (state != ST_IDLE) && writeQ;

  assert_done_on_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    accessDone |-> (state == ST_IDLE && $past(state) != ST_IDLE));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    accessDone |=> !accessDone);
  assert_unhonoured_short_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && !honourQ) |=> accessDone);
endmodule

// File: rtl/wait_state_ctrl.sv
module wait_state_ctrl
  import wsc_pkg::*;
#(
  parameter int WAIT_WINDOW = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic        accStart,
  input  logic [2:0]  accArea,
  input  logic        accWrite,
  input  logic        accSdram,
  input  logic [3:0]  areaWaitOn,
  input  logic        extWait,
  output logic        rdStrobe,
  output logic        wrStrobe,
  output logic        accessDone
);
  ctlStrobes_t strobes;
  logic honourQ, writeQ, waitSync, seenQ, holdZero, winLast;

  wsc_datapath #(.WAIT_WINDOW(WAIT_WINDOW), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .accArea(accArea), .accWrite(accWrite), .accSdram(accSdram), .areaWaitOn(areaWaitOn),
    .extWait(extWait), .strobes(strobes), .honourQ(honourQ), .writeQ(writeQ),
    .waitSync(waitSync), .seenQ(seenQ), .holdZero(holdZero), .winLast(winLast));

  wsc_control u_ctl (
    .clk(clk), .rstN(rstN), .accStart(accStart), .honourQ(honourQ), .writeQ(writeQ),
    .waitSync(waitSync), .seenQ(seenQ), .holdZero(holdZero), .winLast(winLast),
    .strobes(strobes), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .accessDone(accessDone));
endmodule

// File: tb/tb_wait_state_ctrl.sv
module tb_wait_state_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        accStart = 1'b0;
  logic [2:0]  accArea = '0;
  logic        accWrite = 1'b0;
  logic        accSdram = 1'b0;
  logic [3:0]  areaWaitOn = 4'hF;
  logic        extWait = 1'b0;
  logic        rdStrobe, wrStrobe, accessDone;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit summaryDone = 0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cycles <= cycles + 1;

  wait_state_ctrl dut (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic writeCfg(input logic [15:0] val);
    @(negedge clk);
    regWdata = val;
    regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // Reference: strobe held from the start edge (index 0) until edge expFall,
  // done high only after edge expFall. Wait pin raised with the start, dropped before edge 3.
  task automatic access(input string tag, input logic [2:0] area, input logic wr,
                        input logic sdram, input logic useWait, input int expFall);
    @(negedge clk);
    accArea = area; accWrite = wr; accSdram = sdram;
    accStart = 1'b1; extWait = useWait;
    for (int i = 0; i <= expFall + 2; i++) begin
      @(negedge clk);
      if (i == 0) accStart = 1'b0;
      check({tag, " rd"},   {15'd0, rdStrobe},   {15'd0, (!wr && i < expFall)});
      check({tag, " wr"},   {15'd0, wrStrobe},   {15'd0, (wr && i < expFall)});
      check({tag, " done R9"}, {15'd0, accessDone}, {15'd0, (i == expFall)});
      if (i == 2) extWait = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset value", regRdata, 16'h000B);
    check("R9 idle done", {15'd0, accessDone}, 16'd0);
    writeCfg(16'hFFFF);
    check("R2 read-only bits", regRdata, 16'hDF0F);
    writeCfg(16'h0000);
    check("R2 clear", regRdata, 16'h0000);

    // R3: delay codes, release accepted at edge 5, strobe falls 5+D
    writeCfg(16'h0003); access("R3 code00", 3'd4, 1'b0, 1'b0, 1'b1, 6);
    writeCfg(16'h4003); access("R3 code01", 3'd4, 1'b1, 1'b0, 1'b1, 7);
    writeCfg(16'h8003); access("R3 code10", 3'd4, 1'b0, 1'b0, 1'b1, 9);
    writeCfg(16'hC003); access("R4 code11", 3'd4, 1'b1, 1'b0, 1'b1, 9);
    // R8: areas 0..3 ignore the delay code
    for (int a = 0; a < 4; a++) access("R8 low area", 3'(a), a[0], 1'b0, 1'b1, 6);
    // R5: ignore bits, with unmasked neighbour kept
    for (int a = 0; a < 5; a++) begin
      writeCfg(16'h8003 | (16'h0100 << a));
      access("R5 masked", 3'(a), 1'b0, 1'b0, 1'b1, 1);
    end
    writeCfg(16'h0103);
    access("R5 neighbour", 3'd1, 1'b0, 1'b0, 1'b1, 6);
    // R6: zero wait-control field
    writeCfg(16'h8000);
    access("R6 area4 field0", 3'd4, 1'b0, 1'b0, 1'b1, 1);
    areaWaitOn = 4'b1011;
    access("R6 area2 flag0", 3'd2, 1'b1, 1'b0, 1'b1, 1);
    areaWaitOn = 4'hF;
    // R7: DRAM flag
    writeCfg(16'h8003);
    access("R7 sdram", 3'd4, 1'b0, 1'b1, 1'b1, 1);
    access("R7 sdram low", 3'd0, 1'b1, 1'b1, 1'b1, 1);
    // R10: honoured, no wait pulse
    access("R10 window", 3'd4, 1'b0, 1'b0, 1'b0, 3);
    access("R10 window low", 3'd3, 1'b1, 1'b0, 1'b0, 3);

    if (!summaryDone) begin
      summaryDone = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait (cycles > 20000);
    if (!summaryDone) begin
      summaryDone = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule